// File: doc/BRIEF.md
# Watchdog Timer with Selectable Time Base and Prescaler

This block is the watchdog of a small microcontroller core. A static option picks what advances the count: either a one-cycle enable pulse from a slow dedicated oscillator, already brought into the system clock domain, or the instruction clock, which is the system clock divided by four. Every count tick first passes through a fixed 256-step base divider. After that it goes through a prescaler whose ratio comes from the three low bits of an 8-bit control register. When the whole chain wraps, the block emits a one-cycle `timeout` pulse and starts counting again from zero.

The running core keeps the watchdog from expiring by issuing clear commands. A static option chooses how clears work. In single mode, one clear command is enough. In paired mode, two distinct commands must both arrive. A small state machine tracks paired mode with three states. `PAIR_NONE` means nothing has been seen yet. `PAIR_HAVE1` means only clear-1 has been seen. `PAIR_HAVE2` means only clear-2 has been seen. The transitions are:
- `NONE→HAVE1` on clear-1 alone.
- `NONE→HAVE2` on clear-2 alone.
- `HAVE1→NONE` on clear-2, which also clears the counter.
- `HAVE2→NONE` on clear-1, which also clears the counter.
- `NONE→NONE` when both commands arrive in the same cycle, which also clears the counter.
- Any state returns to `NONE` on halt, when the watchdog is disabled, or when single mode is selected.

A halt request also clears the counter. While the core sleeps on the instruction clock, the count holds, because the system clock would be stopped.

Top module: `wdog_timer`

## Requirements
- R1: With select code s in control bits 2:0, the prescaler ratio is: 000→128, 001→16, 010→32, 011→64, 100→1, 101→2, 110→4, 111→8. `timeout` is high after exactly 256×ratio count ticks from the last clear.
- R2: Writing the control register with `ctl_wr` stores all eight bits, and `ctl_rdata` returns them. Bits 7:3 are user flags with no effect on timing.
- R3: With `cfg_use_osc`=1, each `osc_tick` cycle is one count tick. With `cfg_use_osc`=0, one count tick occurs every 4 system clocks, and `osc_tick` is ignored.
- R4: With `cfg_enable`=0, `timeout` never rises and the counter is held at zero, whatever commands arrive.
- R5: After `rst_n` is released, `timeout` is 0, the control register reads 8'h00 (ratio 128), the counter is zero, and the pair state is `PAIR_NONE`.
- R6: `halt_req` clears the base divider and the prescaler, and returns the pair state to `PAIR_NONE`, in any clear mode.
- R7: In single mode (`cfg_pair_mode`=0), `cmd_clr` clears the counter, and `cmd_clr1`/`cmd_clr2` have no effect.
- R8: In paired mode, the counter clears only once both `cmd_clr1` and `cmd_clr2` have arrived, in either order or in the same cycle. Repeating one command does not count twice, and `cmd_clr` has no effect.
- R9: With `core_asleep`=1 and the instruction clock selected, the count holds. With the oscillator selected, the count keeps advancing.
- R10: `timeout` lasts exactly one cycle. The chain restarts from zero, so consecutive pulses are exactly one full period apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low external reset |
| cfg_enable | input | 1 | Static: watchdog enabled |
| cfg_use_osc | input | 1 | Static: 1 = oscillator tick, 0 = instruction clock |
| cfg_pair_mode | input | 1 | Static: 1 = paired clear mode |
| osc_tick | input | 1 | Slow oscillator enable pulse, synchronous |
| core_asleep | input | 1 | Core is halted (system clock notionally stopped) |
| halt_req | input | 1 | Halt command, clears the watchdog |
| cmd_clr | input | 1 | Single-mode clear command |
| cmd_clr1 | input | 1 | Paired-mode clear command 1 |
| cmd_clr2 | input | 1 | Paired-mode clear command 2 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| timeout | output | 1 | One-cycle time-out pulse |

## Verification
The hardest situation to reach from the ports is a paired-mode state that has been half-armed and then receives a repeat of the same command. The only visible effect is when the next `timeout` arrives, several hundred ticks later. The stimulus therefore starts each run from a halt-driven clear, schedules commands at chosen cycles, and compares the arrival cycle of `timeout` with the cycle predicted from the last command that should have counted. Randomized select codes, flag bytes and sparse oscillator ticks are mixed in, so that the tick count at expiry can be checked against 256×ratio.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int PRE_BITS = 7;

    typedef enum logic [1:0] {
        PAIR_NONE  = 2'd0,
        PAIR_HAVE1 = 2'd1,
        PAIR_HAVE2 = 2'd2
    } pair_state_e;

    // Select code to prescaler terminal mask (ratio - 1).
    function automatic logic [PRE_BITS-1:0] ratio_mask(input logic [2:0] sel);
        logic [PRE_BITS-1:0] m;
        unique case (sel)
            3'b000:  m = 7'd127;
            3'b001:  m = 7'd15;
            3'b010:  m = 7'd31;
            3'b011:  m = 7'd63;
            3'b100:  m = 7'd0;
            3'b101:  m = 7'd1;
            3'b110:  m = 7'd3;
            default: m = 7'd7;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src #(
    parameter int INSTR_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_osc,
    input  logic osc_tick,
    input  logic core_asleep,
    output logic tick
);
    localparam int DIV_W = (INSTR_DIV > 2) ? $clog2(INSTR_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INSTR_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             instr_tick;

    // Instruction-clock phase counter; frozen while the core sleeps.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!core_asleep) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    always_comb begin
        instr_tick = !core_asleep && (div_q == DIV_LAST);
        tick       = use_osc ? osc_tick : instr_tick;
    end

    generate
        if (INSTR_DIV > 1) begin : g_chk
            // R3: instruction ticks never fall on adjacent cycles
            assert_instr_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!use_osc && tick) |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wdog_clear_fsm.sv
module wdog_clear_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pair_mode,
    input  logic halt_req,
    input  logic cmd_clr,
    input  logic cmd_clr1,
    input  logic cmd_clr2,
    output logic sw_clear
);
    pair_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAIR_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!enable || !pair_mode || halt_req) begin
            state_d = PAIR_NONE;
        end else begin
            unique case (state_q)
                PAIR_NONE: begin
                    if (cmd_clr1 && cmd_clr2) state_d = PAIR_NONE;
                    else if (cmd_clr1)        state_d = PAIR_HAVE1;
                    else if (cmd_clr2)        state_d = PAIR_HAVE2;
                end
                PAIR_HAVE1: if (cmd_clr2) state_d = PAIR_NONE;
                PAIR_HAVE2: if (cmd_clr1) state_d = PAIR_NONE;
                default:    state_d = PAIR_NONE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sw_clear = 1'b0;
        if (enable) begin
            if (!pair_mode) begin
                sw_clear = cmd_clr;
            end else begin
                unique case (state_q)
                    PAIR_NONE:  sw_clear = cmd_clr1 && cmd_clr2;
                    PAIR_HAVE1: sw_clear = cmd_clr2;
                    PAIR_HAVE2: sw_clear = cmd_clr1;
                    default:    sw_clear = 1'b0;
                endcase
            end
        end
    end

    // R8: completing the pair returns to NONE
    assert_pair_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pair_mode && !halt_req && state_q == PAIR_HAVE1 && cmd_clr2)
            |=> state_q == PAIR_NONE);
    // R8: a repeated clear-1 keeps the armed state and does not clear
    assert_pair_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pair_mode && !halt_req && state_q == PAIR_HAVE1 && cmd_clr1 && !cmd_clr2)
            |=> state_q == PAIR_HAVE1);
    // R7: single mode never holds an armed state
    assert_single_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_mode |=> state_q == PAIR_NONE);
    // R6: halt drops any half-armed pair
    assert_halt_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> state_q == PAIR_NONE);

endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
    parameter int BASE_BITS = 8,
    parameter int PRE_BITS  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                tick,
    input  logic [PRE_BITS-1:0] mask,
    output logic                wrap
);
    localparam logic [BASE_BITS-1:0] BASE_LAST = '1;

    logic [BASE_BITS-1:0] base_q;
    logic [PRE_BITS-1:0]  pre_q;
    logic                 wrap_q;
    logic                 base_end;
    logic                 pre_end;

    always_comb begin
        base_end = (base_q == BASE_LAST);
        pre_end  = ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            pre_q  <= '0;
            wrap_q <= 1'b0;
        end else if (clear) begin
            base_q <= '0;
            pre_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= tick && base_end && pre_end;
            if (tick) begin
                base_q <= base_q + 1'b1;
                if (base_end) begin
                    pre_q <= pre_end ? '0 : ((pre_q + 1'b1) & mask);
                end
            end
        end
    end

    assign wrap = wrap_q;

    // R6: any clear leaves both stages at zero
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (base_q == '0 && pre_q == '0));
    // R10: a wrap pulse coincides with a fresh chain
    assert_wrap_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (base_q == '0 && pre_q == '0));
    // R10: single-cycle pulse
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |=> !wrap_q);
    // R9: no tick, no clear means the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> ($stable(base_q) && $stable(pre_q)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int INSTR_DIV = 4,
    parameter int BASE_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_use_osc,
    input  logic       cfg_pair_mode,
    input  logic       osc_tick,
    input  logic       core_asleep,
    input  logic       halt_req,
    input  logic       cmd_clr,
    input  logic       cmd_clr1,
    input  logic       cmd_clr2,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    output logic       timeout
);
    logic [7:0]          ctl_q;
    logic                raw_tick;
    logic                sw_clear;
    logic                chain_clear;
    logic                chain_tick;
    logic [PRE_BITS-1:0] pre_mask;

    // Control register: bits 2:0 select, bits 7:3 user flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= 8'h00;
        end else if (ctl_wr) begin
            ctl_q <= ctl_wdata;
        end
    end

    always_comb begin
        pre_mask    = ratio_mask(ctl_q[2:0]);
        chain_clear = !cfg_enable || halt_req || sw_clear;
        chain_tick  = cfg_enable && raw_tick;
        ctl_rdata   = ctl_q;
    end

    wdog_tick_src #(.INSTR_DIV(INSTR_DIV)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_osc    (cfg_use_osc),
        .osc_tick   (osc_tick),
        .core_asleep(core_asleep),
        .tick       (raw_tick)
    );

    wdog_clear_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_enable),
        .pair_mode(cfg_pair_mode),
        .halt_req (halt_req),
        .cmd_clr  (cmd_clr),
        .cmd_clr1 (cmd_clr1),
        .cmd_clr2 (cmd_clr2),
        .sw_clear (sw_clear)
    );

    wdog_chain #(.BASE_BITS(BASE_BITS), .PRE_BITS(PRE_BITS)) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(chain_clear),
        .tick (chain_tick),
        .mask (pre_mask),
        .wrap (timeout)
    );

    // R4: a disabled watchdog stays silent
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !timeout);
    // R2: the register changes only on a write
    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctl_rdata));
    // R6: a halt never lets a pulse through on the next cycle
    assert_halt_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !timeout);

endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b1, cfg_use_osc = 1'b1, cfg_pair_mode = 1'b0;
    logic       osc_tick = 1'b0, core_asleep = 1'b0, halt_req = 1'b0;
    logic       cmd_clr = 1'b0, cmd_clr1 = 1'b0, cmd_clr2 = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       timeout;

    int  n_pass = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    wdog_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_use_osc(cfg_use_osc),
        .cfg_pair_mode(cfg_pair_mode), .osc_tick(osc_tick), .core_asleep(core_asleep),
        .halt_req(halt_req), .cmd_clr(cmd_clr), .cmd_clr1(cmd_clr1), .cmd_clr2(cmd_clr2),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .timeout(timeout)
    );

    function automatic int exp_ratio(input logic [2:0] sel);
        case (sel)
            3'd0: return 128;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 64;
            3'd4: return 1;
            3'd5: return 2;
            3'd6: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_ticks(input logic [2:0] sel);
        return 256 * exp_ratio(sel);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        if (ok) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // Commands: {halt, clr2, clr1, clr}. A halt is issued at cycle 0.
    // A clear driven at cycle c produces timeout at cycle c+1+N.
    task automatic measure(input int at1, input logic [3:0] c1,
                           input int at2, input logic [3:0] c2,
                           input bit rnd_osc, input int limit,
                           output int cnt, output int ticks, output bit seen);
        logic [3:0] c;
        cnt = 0; ticks = 0; seen = 0;
        while (cnt < limit && !seen) begin
            @(negedge clk);
            c = (cnt == 0) ? 4'b1000 : 4'b0000;
            if (cnt == at1) c = c | c1;
            if (cnt == at2) c = c | c2;
            {halt_req, cmd_clr2, cmd_clr1, cmd_clr} = c;
            osc_tick = rnd_osc ? (($urandom % 3) == 0) : 1'b1;
            if (osc_tick && cnt >= 1) ticks++;
            @(posedge clk); #1;
            cnt++;
            seen = timeout;
        end
        @(negedge clk);
        {halt_req, cmd_clr2, cmd_clr1, cmd_clr} = 4'b0000;
    endtask

    task automatic measure_period(input int limit, output int period);
        int guard;
        guard = 0;
        while (!timeout && guard < limit) begin @(posedge clk); #1; guard++; end
        @(posedge clk); #1;
        period = 1;
        while (!timeout && period < limit) begin @(posedge clk); #1; period++; end
    endtask

    task automatic finish_run;
        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int cnt, tk, per, n;
        bit seen;
        logic [2:0] sel;
        logic [7:0] v;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(timeout == 1'b0, "R5", "timeout after reset", timeout, 0);
        check(ctl_rdata == 8'h00, "R5", "ctl after reset", ctl_rdata, 0);

        // R5/R1: reset value selects 1:128
        cfg_use_osc = 1'b1;
        n = exp_ticks(3'd0);
        measure(-1, 4'b0, -1, 4'b0, 1'b0, n + 10, cnt, tk, seen);
        check(seen && cnt == n + 1, "R1", "default 1:128 expiry", cnt, n + 1);

        // R1: 1:32 directed
        write_ctl(8'h02);
        n = exp_ticks(3'd2);
        measure(-1, 4'b0, -1, 4'b0, 1'b0, n + 10, cnt, tk, seen);
        check(seen && cnt == n + 1, "R1", "1:32 expiry", cnt, n + 1);

        // Random select codes (short ratios) with random flags
        for (int i = 0; i < 6; i++) begin
            case ($urandom % 5)
                0: sel = 3'd1;
                1: sel = 3'd4;
                2: sel = 3'd5;
                3: sel = 3'd6;
                default: sel = 3'd7;
            endcase
            v = {$urandom % 32, sel};
            v = {v[7:3], sel};
            write_ctl(v);
            check(ctl_rdata == v, "R2", "control readback", ctl_rdata, v);
            n = exp_ticks(sel);
            measure(-1, 4'b0, -1, 4'b0, 1'b0, n + 10, cnt, tk, seen);
            check(seen && cnt == n + 1, "R1", "random ratio expiry", cnt, n + 1);
            if (exp_ratio(sel) <= 4) begin
                measure(-1, 4'b0, -1, 4'b0, 1'b1, 4 * n + 40, cnt, tk, seen);
                check(seen && tk == n, "R3", "sparse osc ticks at expiry", tk, n);
            end
        end

        // Paired and single clear modes at ratio 1:2
        write_ctl(8'hA5);
        check(ctl_rdata == 8'hA5, "R2", "flags readback", ctl_rdata, 8'hA5);
        n = exp_ticks(3'd5);
        cfg_pair_mode = 1'b1;
        measure(100, 4'b0010, 150, 4'b0010, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 1, "R8", "repeated clear-1 ignored", cnt, n + 1);
        measure(100, 4'b0010, 200, 4'b0100, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 201, "R8", "clear-1 then clear-2", cnt, n + 201);
        measure(100, 4'b0100, 250, 4'b0010, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 251, "R8", "clear-2 then clear-1", cnt, n + 251);
        measure(100, 4'b0110, -1, 4'b0, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 101, "R8", "both in one cycle", cnt, n + 101);
        measure(100, 4'b0001, -1, 4'b0, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 1, "R8", "single clear ignored in pair mode", cnt, n + 1);
        measure(300, 4'b1000, -1, 4'b0, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 301, "R6", "halt clears in pair mode", cnt, n + 301);

        cfg_pair_mode = 1'b0;
        measure(300, 4'b0001, -1, 4'b0, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 301, "R7", "single clear", cnt, n + 301);
        measure(100, 4'b0010, 200, 4'b0100, 1'b0, n + 400, cnt, tk, seen);
        check(cnt == n + 1, "R7", "pair commands ignored in single mode", cnt, n + 1);

        // R4: disabled
        cfg_enable = 1'b0;
        measure(100, 4'b0001, 200, 4'b1000, 1'b0, 3 * n, cnt, tk, seen);
        check(!seen && cnt == 3 * n, "R4", "disabled, cycles without timeout", cnt, 3 * n);
        cfg_enable = 1'b1;

        // R9: sleep with oscillator keeps counting
        core_asleep = 1'b1;
        measure(-1, 4'b0, -1, 4'b0, 1'b0, n + 10, cnt, tk, seen);
        check(seen && cnt == n + 1, "R9", "osc runs while asleep", cnt, n + 1);

        // R3/R9/R10: instruction clock at 1:1
        write_ctl(8'h04);
        n = exp_ticks(3'd4);
        cfg_use_osc = 1'b0;
        measure(-1, 4'b0, -1, 4'b0, 1'b0, 3000, cnt, tk, seen);
        check(!seen && cnt == 3000, "R9", "instr clock holds while asleep", cnt, 3000);
        core_asleep = 1'b0;
        measure_period(4 * n + 20, per);
        check(per == 4 * n, "R3", "instr clock period", per, 4 * n);
        @(posedge clk); #1;
        check(timeout == 1'b0, "R10", "pulse one cycle", timeout, 0);
        measure_period(4 * n + 20, per);
        check(per == 4 * n, "R10", "restart gives same period", per, 4 * n);

        finish_run();
    end

endmodule